// File: doc/BRIEF.md
# One-Wire ROM Enumeration Sequencer

This block walks a one-wire bus and lists the 64-bit ROM identifier of every device attached to it, without software stepping through each pass. It sits in front of a byte-level bus master and talks to it over four request lines: bus reset with a presence answer, byte write, nibble exchange, and a level that holds the master in its search-accelerator mode. All four share one acknowledge, one failure flag and one receive byte.

A pulse on `start` runs passes until the tree of identifiers is exhausted. Each pass resets the bus and sends the search command byte. It then streams the current path register out as sixteen interleaved nibbles, and reads back the ROM bits chosen on the bus together with a discrepancy bit for each position. It leaves accelerator mode and resets the bus once more. It then either reports the identifier or, on a bit-63 conflict, repeats the pass. The next path is derived from the discrepancy map in a single cycle.

The run ends with a one-cycle `done` and a two-bit status. The count of identifiers found stays on `found_count` until the next start.

Top module: `onewire_enum_seq`

## Requirements
- R1: After reset `busy`, `done`, `id_valid` and all three request lines are low, and `found_count` is zero.
- R2: Every pass follows a fixed order. It starts with a bus reset. Then comes a write of `SEARCH_CMD` (default 0xF0) with `m_acc` low. Then `m_acc` goes high for exactly 16 exchanges. Last, `m_acc` drops and a second bus reset is made. At most one request line is high at any time.
- R3: Exchange number i (0 to 15) sends path bits 4i+k (k = 0..3) on `m_tx` bit 2k+1, and `m_tx` even bits are zero.
- R4: The reply to exchange i gives ROM bit 4i+k from `m_rx` bit 2k+1 and discrepancy bit 4i+k from `m_rx` bit 2k. The reported identifier is the ROM assembled from all 16 replies.
- R5: If the first reset of a pass sees no presence, the run ends with status 1 and no further request.
- R6: If ROM bit 63 and discrepancy bit 63 are both set, the pass emits no identifier and is repeated with an unchanged path.
- R7: Otherwise the ROM is output for one cycle on `id_rom` with `id_valid`, and `found_count` rises by one in that same cycle.
- R8: The next path is formed by taking the discrepancy bits that are not already 1 in the path, with highest such position m. The new path keeps the path bits below m, sets bit m and clears every bit above m.
- R9: When no such discrepancy remains, the run ends with status 0.
- R10: At most `MAX_PASSES` (default 100) passes run. A run that needs one more ends with status 3.
- R11: An acknowledge carrying `m_fail` ends the run with status 2 and leaves `found_count` as it was.
- R12: `busy` rises the cycle after `start` and falls in the cycle `done` pulses for one cycle.
- R13: The first pass of every run uses an all-zero path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to begin an enumeration |
| busy | output | 1 | Enumeration in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| status | output | 2 | 0 finished, 1 no presence, 2 sub-operation failure, 3 pass limit |
| found_count | output | CNT_W | Identifiers reported in this run |
| id_valid | output | 1 | One-cycle strobe for `id_rom` |
| id_rom | output | ID_W | Identifier found |
| m_rst_req | output | 1 | Bus reset request, held until acknowledge |
| m_wr_req | output | 1 | Byte write request, held until acknowledge |
| m_xchg_req | output | 1 | Nibble exchange request, held until acknowledge |
| m_acc | output | 1 | Search-accelerator mode level |
| m_tx | output | 8 | Byte for write or exchange |
| m_ack | input | 1 | Completion of the pending request |
| m_fail | input | 1 | With `m_ack`: the request timed out or failed |
| m_presence | input | 1 | With a reset `m_ack`: a device answered |
| m_rx | input | 8 | With an exchange `m_ack`: reply byte |

## Verification
The assertions assume that the bus master raises `m_ack` only while a request is pending, holds it for one cycle, and presents `m_fail`, `m_presence` and `m_rx` in that same cycle. They also assume `start` is pulsed only while the block is idle. The bench's responder reacts on the falling edge to the request it sees. It drops the acknowledge before it answers again, so a request line always falls before the next one rises. Its replies come from a model of up to four devices that resolves each bit position. It can force bit-63 conflicts or fail a chosen operation.

// File: rtl/onewire_enum_seq.sv
module onewire_enum_seq #(
  parameter int ID_W       = 64,
  parameter logic [7:0] SEARCH_CMD = 8'hF0,
  parameter int MAX_PASSES = 100,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic [1:0]       status,
  output logic [CNT_W-1:0] found_count,
  output logic             id_valid,
  output logic [ID_W-1:0]  id_rom,
  output logic             m_rst_req,
  output logic             m_wr_req,
  output logic             m_xchg_req,
  output logic             m_acc,
  output logic [7:0]       m_tx,
  input  logic             m_ack,
  input  logic             m_fail,
  input  logic             m_presence,
  input  logic [7:0]       m_rx
);
  localparam int NIB    = ID_W / 4;
  localparam int NIB_W  = $clog2(NIB);
  localparam int IDX_W  = $clog2(ID_W);
  localparam int PASS_W = $clog2(MAX_PASSES + 1);

  typedef enum logic [2:0] {S_IDLE, S_BEGIN, S_RST1, S_WR, S_XCH, S_RST2, S_EVAL} st_t;
  st_t st;

  logic [ID_W-1:0]   path, rom, disc, avail, path_nx;
  logic [NIB_W-1:0]  nib;
  logic [PASS_W-1:0] pass_cnt;
  logic [IDX_W-1:0]  top;
  logic              has_disc;
  logic [3:0]        cur;

  assign busy       = (st != S_IDLE);
  assign m_rst_req  = (st == S_RST1) || (st == S_RST2);
  assign m_wr_req   = (st == S_WR);
  assign m_xchg_req = (st == S_XCH);
  assign cur        = path[{nib, 2'b00} +: 4];
  assign m_tx       = (st == S_WR) ? SEARCH_CMD
                                   : {cur[3], 1'b0, cur[2], 1'b0, cur[1], 1'b0, cur[0], 1'b0};

  always_comb begin
    avail    = disc & ~path;
    has_disc = 1'b0;
    top      = '0;
    for (int k = 0; k < ID_W; k++)
      if (avail[k]) begin
        top      = IDX_W'(k);
        has_disc = 1'b1;
      end
    for (int k = 0; k < ID_W; k++)
      path_nx[k] = (IDX_W'(k) < top) ? path[k] : (IDX_W'(k) == top);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; path <= '0; rom <= '0; disc <= '0; nib <= '0;
      pass_cnt <= '0; found_count <= '0; status <= 2'd0;
      done <= 1'b0; id_valid <= 1'b0; id_rom <= '0; m_acc <= 1'b0;
    end else begin
      done     <= 1'b0;
      id_valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          path <= '0; pass_cnt <= '0; found_count <= '0; status <= 2'd0;
          st <= S_BEGIN;
        end
        S_BEGIN:
          if (pass_cnt == PASS_W'(MAX_PASSES)) begin
            st <= S_IDLE; done <= 1'b1; status <= 2'd3;
          end else begin
            pass_cnt <= pass_cnt + 1'b1;
            st <= S_RST1;
          end
        S_RST1: if (m_ack) begin
          if (m_fail || !m_presence) begin
            st <= S_IDLE; done <= 1'b1; status <= m_fail ? 2'd2 : 2'd1;
          end else st <= S_WR;
        end
        S_WR: if (m_ack) begin
          if (m_fail) begin
            st <= S_IDLE; done <= 1'b1; status <= 2'd2;
          end else begin
            m_acc <= 1'b1; nib <= '0; st <= S_XCH;
          end
        end
        S_XCH: if (m_ack) begin
          if (m_fail) begin
            st <= S_IDLE; done <= 1'b1; status <= 2'd2; m_acc <= 1'b0;
          end else begin
            rom[{nib, 2'b00} +: 4]  <= {m_rx[7], m_rx[5], m_rx[3], m_rx[1]};
            disc[{nib, 2'b00} +: 4] <= {m_rx[6], m_rx[4], m_rx[2], m_rx[0]};
            if (nib == NIB_W'(NIB - 1)) begin
              m_acc <= 1'b0; st <= S_RST2;
            end else nib <= nib + 1'b1;
          end
        end
        S_RST2: if (m_ack) begin
          if (m_fail) begin
            st <= S_IDLE; done <= 1'b1; status <= 2'd2;
          end else st <= S_EVAL;
        end
        S_EVAL:
          if (rom[ID_W-1] && disc[ID_W-1]) st <= S_BEGIN;
          else begin
            id_valid    <= 1'b1;
            id_rom      <= rom;
            found_count <= found_count + 1'b1;
            if (has_disc) begin
              path <= path_nx; st <= S_BEGIN;
            end else begin
              st <= S_IDLE; done <= 1'b1; status <= 2'd0;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_one_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({m_rst_req, m_wr_req, m_xchg_req}));
  assert_acc_in_exchange_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_xchg_req |-> m_acc);
  assert_acc_off_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_wr_req |-> !m_acc);
  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |-> found_count == $past(found_count) + 1'b1);
  assert_pass_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pass_cnt <= PASS_W'(MAX_PASSES));
  assert_busy_from_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  assert_done_ends_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/onewire_enum_seq_tb.sv
module onewire_enum_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, id_valid, m_rst_req, m_wr_req, m_xchg_req, m_acc;
  logic [1:0] status;
  logic [7:0] found_count, m_tx;
  logic [63:0] id_rom;
  logic m_ack = 1'b0, m_fail = 1'b0, m_presence = 1'b0;
  logic [7:0] m_rx = 8'h00;

  always #5 clk = ~clk;

  onewire_enum_seq dut_i (.clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .status(status), .found_count(found_count), .id_valid(id_valid), .id_rom(id_rom),
    .m_rst_req(m_rst_req), .m_wr_req(m_wr_req), .m_xchg_req(m_xchg_req), .m_acc(m_acc),
    .m_tx(m_tx), .m_ack(m_ack), .m_fail(m_fail), .m_presence(m_presence), .m_rx(m_rx));

  int n_chk = 0, n_bad = 0;
  logic [63:0] dev [4];
  int ndev, phase, nibi, opn, fail_at, err_passes, npass, nid, ord_err, even_err;
  logic [3:0] active;
  logic [63:0] cur_path;
  logic [63:0] pass_path [128];
  logic [63:0] ids [16];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (id_valid && nid < 16) begin ids[nid] = id_rom; nid++; end
  end

  initial forever begin
    @(negedge clk);
    if (m_ack) begin
      m_ack = 1'b0; m_fail = 1'b0;
    end else if (m_rst_req || m_wr_req || m_xchg_req) begin
      opn++;
      if (m_rst_req) begin
        if (phase == 0) begin
          m_presence = (ndev > 0); active = 4'b0; cur_path = '0;
          for (int j = 0; j < ndev; j++) active[j] = 1'b1;
          phase = 1;
        end else if (phase == 3) begin
          if (npass < 128) pass_path[npass] = cur_path;
          npass++; phase = 0;
        end else ord_err++;
      end else if (m_wr_req) begin
        if (phase != 1 || m_acc || m_tx != 8'hF0) ord_err++;
        phase = 2; nibi = 0;
      end else begin
        if (phase != 2 || !m_acc) ord_err++;
        if ((m_tx & 8'h55) != 0) even_err++;
        for (int k = 0; k < 4; k++) begin
          int p;
          bit c, has0, has1, rb, db;
          p = 4 * nibi + k;
          c = m_tx[2*k+1];
          cur_path[p] = c;
          has0 = 0; has1 = 0;
          for (int j = 0; j < 4; j++)
            if (active[j]) begin if (dev[j][p]) has1 = 1; else has0 = 0 | 1'b1 & ~dev[j][p]; end
          if (has0 && has1) begin rb = c; db = 1; end
          else if (has1) begin rb = 1; db = 0; end
          else if (has0) begin rb = 0; db = 0; end
          else begin rb = 1; db = 1; end
          if (p == 63 && err_passes > 0) begin rb = 1; db = 1; err_passes--; end
          for (int j = 0; j < 4; j++) if (active[j] && dev[j][p] != rb) active[j] = 1'b0;
          m_rx[2*k+1] = rb; m_rx[2*k] = db;
        end
        nibi++;
        if (nibi == 16) phase = 3;
      end
      if (opn == fail_at) begin m_fail = 1'b1; phase = 0; end
      m_ack = 1'b1;
    end
  end

  task automatic setup(input int n, input int errs, input int fat);
    ndev = n; err_passes = errs; fail_at = fat;
    phase = 0; opn = 0; npass = 0; nid = 0; ord_err = 0; even_err = 0;
  endtask

  task automatic run_enum();
    int t;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R12 busy after start", busy, 1);
    t = 0;
    while (!done && t < 50000) begin @(negedge clk); t++; end
    check(done && !busy, "R12 done with busy low", {busy, done}, 2'b01);
    @(negedge clk);
    check(done == 1'b0, "R12 done single cycle", done, 0);
  endtask

  task automatic t_reset();
    check(!busy && !done && !id_valid && !m_rst_req && !m_wr_req && !m_xchg_req && found_count == 0,
          "R1 reset state", {busy, done, id_valid, m_rst_req, m_wr_req, m_xchg_req}, 0);
  endtask

  task automatic t_two_devices();
    dev[0] = 64'h0123_4567_89AB_CDC0; dev[1] = 64'h0123_4567_89AB_CDE0;
    setup(2, 0, 0); run_enum();
    check(status == 0, "R9 status ok", status, 0);
    check(found_count == 2, "R7 found count", found_count, 2);
    check(ids[0] == dev[0], "R4 first id", ids[0], dev[0]);
    check(ids[1] == dev[1], "R7 second id", ids[1], dev[1]);
    check(npass == 2, "R9 pass count", npass, 2);
    check(pass_path[0] == 0, "R13 first path zero", pass_path[0], 0);
    check(pass_path[1] == 64'h20, "R8 next path", pass_path[1], 64'h20);
    check(ord_err == 0, "R2 request order", ord_err, 0);
    check(even_err == 0, "R3 even tx bits zero", even_err, 0);
  endtask

  task automatic t_three_devices();
    int hits;
    dev[0] = 64'h5A00_0000_0000_0010; dev[1] = 64'h5A00_0000_0000_0011; dev[2] = 64'h5A00_0000_0000_0003;
    setup(3, 0, 0); run_enum();
    check(found_count == 3 && status == 0, "R9 three devices", {status, found_count}, 3);
    check(npass == 3, "R8 three passes", npass, 3);
    hits = 0;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++) if (ids[i] == dev[j]) hits = hits + (1 << (j * 4));
    check(hits == 32'h111, "R4 each id once", hits, 32'h111);
    check(pass_path[0] == 0, "R13 path reset per run", pass_path[0], 0);
  endtask

  task automatic t_no_device();
    setup(0, 0, 0); run_enum();
    check(status == 1, "R5 no presence status", status, 1);
    check(found_count == 0 && nid == 0 && opn == 1, "R5 no id and single request",
          {found_count, 8'(nid), 8'(opn)}, 1);
  endtask

  task automatic t_bus_error();
    dev[0] = 64'h0000_1111_2222_3333;
    setup(1, 2, 0); run_enum();
    check(npass == 3, "R6 repeated passes", npass, 3);
    check(nid == 1 && ids[0] == dev[0], "R6 single id", ids[0], dev[0]);
    check(pass_path[1] == 0 && pass_path[2] == 0, "R6 path unchanged", pass_path[2], 0);
    check(status == 0, "R9 status after retries", status, 0);
  endtask

  task automatic t_limit();
    dev[0] = 64'h0000_1111_2222_3333;
    setup(1, 100000, 0); run_enum();
    check(status == 3, "R10 limit status", status, 3);
    check(npass == 100, "R10 passes run", npass, 100);
    check(found_count == 0, "R10 no id", found_count, 0);
  endtask

  task automatic t_fail();
    dev[0] = 64'h0123_4567_89AB_CDC0; dev[1] = 64'h0123_4567_89AB_CDE0;
    setup(2, 0, 22); run_enum();
    check(status == 2, "R11 failure status", status, 2);
    check(found_count == 1, "R11 count kept", found_count, 1);
    check(m_acc == 0, "R11 accelerator released", m_acc, 0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_two_devices();
    t_three_devices();
    t_no_device();
    t_bus_error();
    t_limit();
    t_fail();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule